// File: doc/BRIEF.md
# Fuse Array Register Front End

This block is the register-mapped side of a one-time-programmable fuse store of up to 128 words of 32 bits. Software sees a control/status register with separate set and clear aliases, a timing register passed straight to the fuse sequencer, a data register that starts a program operation, and a window of shadow words that mirror the fuse contents. The fuse sequencer is a separate block. It receives a one-cycle program request with a captured word address and data, or a one-cycle reload request. During a reload it writes fuse words back into the shadows through a fill port. It signals the end of either operation with a done pulse.

Programming is guarded in three ways. A key must be placed in the upper half of the control register before every program, and the key clears itself when the data register is written. Per-word write-lock and read-lock vectors are static inputs. A sticky error flag blocks new program, reload and shadow accesses until software clears it through the clear alias. Reads of a read-locked shadow word return the pattern 0xBADABADA rather than the word.

Bus reads return data on `bus_rdata` one clock after the read request. A write takes effect at the clock edge that samples the request.

Top module: `fuse_regif`

## Requirements
- R1: After reset, the control register reads 0, the timing, data and shadow registers read 0, and neither `prog_req` nor `reload_req` is asserted.
- R2: The control register (byte offset 0x000) holds the word address in bits [6:0], BUSY in bit 8, ERROR in bit 9, RELOAD in bit 10 and the unlock field in bits [31:16]. The other bits read 0. A write to 0x000 loads the address and unlock fields. A write to 0x004 ORs 1-bits into them. A write to 0x008 clears the bits that are 1 in the written value. Reads of 0x004 and 0x008 return the control register.
- R3: A data-register write (offset 0x020) is accepted when the unlock field equals 0x3E77, BUSY and ERROR are clear, and the addressed word is neither write-locked nor at or above WORDS. Such a write stores the data, asserts `prog_req` for exactly one cycle with `prog_addr` equal to the address field and `prog_data` equal to the written value, sets BUSY, and clears the unlock field. A second data write without re-arming starts nothing.
- R4: While BUSY is set, writes to the data register are ignored. Changes to the address field have no effect on `prog_addr` or `prog_data`.
- R5: An armed data write to a write-locked word produces no `prog_req`, leaves BUSY clear, sets ERROR and clears the unlock field.
- R6: A data write while not armed and not busy stores the value, readable at 0x020, and starts no operation.
- R7: Shadow word n is read at byte offset 0x400 + 0x10*n. A read of a read-locked word returns 0xBADABADA and sets ERROR.
- R8: A write to shadow word n stores the value. If the word is write-locked, or if a reload is in progress, the write instead sets ERROR and the word is unchanged.
- R9: While ERROR is set, program and reload requests are not started, shadow writes are ignored, and shadow reads return 0xBADABADA. ERROR is cleared only by writing 1 to bit 9 through the clear alias at 0x008.
- R10: Writing 1 to bit 10 (at 0x000 or 0x004) while BUSY and ERROR are clear sets BUSY and RELOAD and pulses `reload_req` for one cycle. Otherwise the write has no effect on BUSY or RELOAD. Fill writes update shadow words only while RELOAD is set. `seq_done` clears BUSY and RELOAD.
- R11: The timing register (0x010) reads back the written value and drives `timing_cfg`. Reads of undecoded offsets, unaligned shadow offsets and shadow offsets at or above word WORDS return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| wr_lock | input | WORDS | Per-word program/shadow-write lock |
| rd_lock | input | WORDS | Per-word read lock |
| timing_cfg | output | 32 | Timing register contents for the sequencer |
| prog_req | output | 1 | One-cycle program start |
| prog_addr | output | 7 | Captured word address of the program |
| prog_data | output | 32 | Word to program |
| reload_req | output | 1 | One-cycle shadow reload start |
| seq_done | input | 1 | Sequencer finished the current operation |
| fill_valid | input | 1 | Reload data for one shadow word |
| fill_idx | input | 7 | Word index of the fill |
| fill_data | input | 32 | Fill value |

## Verification
A wrong BUSY or ERROR bit appears in the very next control read. It also changes whether the next data write raises `prog_req` in the cycle after that write, so a gate that arms or blocks wrongly shows within two clocks of the access that should have been gated. A corrupted shadow word, or a missing poison substitution, appears in the first read of that word. The sweep reads back every word after writing it, and every word-address value after setting it. A captured address that drifts during an operation shows on `prog_addr` while BUSY is still set.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int ADDR_W = 12;
    localparam int WIDX_W = 7;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
    localparam logic [31:0] POISON     = 32'hBADA_BADA;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CSET   = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CCLR   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_TIMING = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_SHADOW = 12'h400;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CSET,
        SEL_CCLR,
        SEL_TIMING,
        SEL_DATA,
        SEL_SHADOW
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e            sel;
        logic [WIDX_W-1:0]   idx;
    } dec_t;

    typedef struct packed {
        logic [15:0]       unlock;
        logic [4:0]        rsv_hi;
        logic              reload;
        logic              err;
        logic              busy;
        logic              rsv_lo;
        logic [WIDX_W-1:0] addr;
    } ctrl_t;

endpackage

// File: rtl/fuse_addr_dec.sv
module fuse_addr_dec
    import fuse_pkg::*;
#(
    parameter int WORDS = 128
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [7:0] LIMIT = 8'(WORDS);

    logic [ADDR_W-1:0] rel;
    assign rel = addr - OFS_SHADOW;

    always_comb begin
        dec.sel = SEL_NONE;
        dec.idx = rel[10:4];
        case (addr)
            OFS_CTRL:   dec.sel = SEL_CTRL;
            OFS_CSET:   dec.sel = SEL_CSET;
            OFS_CCLR:   dec.sel = SEL_CCLR;
            OFS_TIMING: dec.sel = SEL_TIMING;
            OFS_DATA:   dec.sel = SEL_DATA;
            default: begin
                if (addr >= OFS_SHADOW && rel[3:0] == 4'h0 && rel[11:4] < LIMIT)
                    dec.sel = SEL_SHADOW;
            end
        endcase
    end
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank
    import fuse_pkg::*;
#(
    parameter int WORDS = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [WIDX_W-1:0] idx,
    input  logic [31:0]       wdata,
    input  logic [WORDS-1:0]  wr_lock,
    input  logic [WORDS-1:0]  rd_lock,
    input  logic              reloading,
    input  logic              err_q,
    input  logic              fill_valid,
    input  logic [WIDX_W-1:0] fill_idx,
    input  logic [31:0]       fill_data,
    output logic [31:0]       rd_word,
    output logic              err_evt
);
    localparam int         IW    = $clog2(WORDS);
    localparam logic [7:0] LIMIT = 8'(WORDS);

    logic [31:0]   mem [WORDS];
    logic [IW-1:0] lidx, fidx;
    logic          wr_ok, fill_ok;

    assign lidx    = idx[IW-1:0];
    assign fidx    = fill_idx[IW-1:0];
    assign wr_ok   = wr_hit && !err_q && !reloading && !wr_lock[lidx];
    assign fill_ok = fill_valid && reloading && ({1'b0, fill_idx} < LIMIT);

    assign err_evt = !err_q && ((wr_hit && (reloading || wr_lock[lidx])) ||
                                (rd_hit && rd_lock[lidx]));

    assign rd_word = (err_q || rd_lock[lidx]) ? POISON : mem[lidx];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic bus_we, fill_we;
        assign bus_we  = wr_ok   && (lidx == IW'(g));
        assign fill_we = fill_ok && (fidx == IW'(g));
        always_ff @(posedge clk) begin
            if (rst)          mem[g] <= '0;
            else if (fill_we) mem[g] <= fill_data;
            else if (bus_we)  mem[g] <= wdata;
        end
    end
endmodule

// File: rtl/fuse_ctrl_core.sv
module fuse_ctrl_core
    import fuse_pkg::*;
#(
    parameter int WORDS = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  dec_t              dec,
    input  logic [31:0]       wdata,
    input  logic [WORDS-1:0]  wr_lock,
    input  logic              seq_done,
    input  logic              shadow_err,
    output ctrl_t             ctrl,
    output logic [31:0]       timing,
    output logic [31:0]       data,
    output logic              prog_req,
    output logic [WIDX_W-1:0] prog_addr,
    output logic              reload_req
);
    localparam int         IW    = $clog2(WORDS);
    localparam logic [7:0] LIMIT = 8'(WORDS);

    ctrl_t             cq;
    logic [31:0]       timing_q, data_q;
    logic [WIDX_W-1:0] op_addr_q;
    logic              prog_q, reload_q;

    logic idle, armed, word_locked;
    logic ctrl_direct, ctrl_set, ctrl_clr, timing_wr, data_wr;
    logic prog_go, lock_fault, reload_go, err_clr;

    assign idle        = !cq.busy && !cq.err;
    assign armed       = (cq.unlock == UNLOCK_KEY);
    assign word_locked = ({1'b0, cq.addr} >= LIMIT) || wr_lock[cq.addr[IW-1:0]];

    assign ctrl_direct = wr_stb && dec.sel == SEL_CTRL;
    assign ctrl_set    = wr_stb && dec.sel == SEL_CSET;
    assign ctrl_clr    = wr_stb && dec.sel == SEL_CCLR;
    assign timing_wr   = wr_stb && dec.sel == SEL_TIMING;
    assign data_wr     = wr_stb && dec.sel == SEL_DATA;

    assign prog_go    = data_wr && idle && armed && !word_locked;
    assign lock_fault = data_wr && idle && armed && word_locked;
    assign reload_go  = (ctrl_direct || ctrl_set) && wdata[10] && idle;
    assign err_clr    = ctrl_clr && wdata[9];

    always_ff @(posedge clk) begin
        if (rst) begin
            cq        <= '0;
            timing_q  <= '0;
            data_q    <= '0;
            op_addr_q <= '0;
            prog_q    <= 1'b0;
            reload_q  <= 1'b0;
        end else begin
            prog_q   <= prog_go;
            reload_q <= reload_go;

            if (ctrl_direct) begin
                cq.addr   <= wdata[WIDX_W-1:0];
                cq.unlock <= wdata[31:16];
            end else if (ctrl_set) begin
                cq.addr   <= cq.addr | wdata[WIDX_W-1:0];
                cq.unlock <= cq.unlock | wdata[31:16];
            end else if (ctrl_clr) begin
                cq.addr   <= cq.addr & ~wdata[WIDX_W-1:0];
                cq.unlock <= cq.unlock & ~wdata[31:16];
            end else if (prog_go || lock_fault) begin
                cq.unlock <= '0;
            end

            if (timing_wr)            timing_q  <= wdata;
            if (data_wr && !cq.busy)  data_q    <= wdata;
            if (prog_go)              op_addr_q <= cq.addr;

            if (prog_go || reload_go) cq.busy <= 1'b1;
            else if (seq_done)        cq.busy <= 1'b0;

            if (reload_go)            cq.reload <= 1'b1;
            else if (seq_done)        cq.reload <= 1'b0;

            if (lock_fault || shadow_err) cq.err <= 1'b1;
            else if (err_clr)             cq.err <= 1'b0;
        end
    end

    assign ctrl       = cq;
    assign timing     = timing_q;
    assign data       = data_q;
    assign prog_req   = prog_q;
    assign prog_addr  = op_addr_q;
    assign reload_req = reload_q;
endmodule

// File: rtl/fuse_regif.sv
module fuse_regif
    import fuse_pkg::*;
#(
    parameter int WORDS = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [WORDS-1:0]  wr_lock,
    input  logic [WORDS-1:0]  rd_lock,
    output logic [31:0]       timing_cfg,
    output logic              prog_req,
    output logic [6:0]        prog_addr,
    output logic [31:0]       prog_data,
    output logic              reload_req,
    input  logic              seq_done,
    input  logic              fill_valid,
    input  logic [6:0]        fill_idx,
    input  logic [31:0]       fill_data
);
    dec_t        dec;
    ctrl_t       ctrl_w;
    logic        wr_stb, rd_stb;
    logic [31:0] timing_w, data_w, shadow_word;
    logic        shadow_err;
    logic        busy_w, err_w, reload_w;
    logic [31:0] rdata_q;

    assign wr_stb = bus_req && bus_we;
    assign rd_stb = bus_req && !bus_we;

    fuse_addr_dec #(.WORDS(WORDS)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    fuse_ctrl_core #(.WORDS(WORDS)) u_core (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .dec        (dec),
        .wdata      (bus_wdata),
        .wr_lock    (wr_lock),
        .seq_done   (seq_done),
        .shadow_err (shadow_err),
        .ctrl       (ctrl_w),
        .timing     (timing_w),
        .data       (data_w),
        .prog_req   (prog_req),
        .prog_addr  (prog_addr),
        .reload_req (reload_req)
    );

    assign busy_w   = ctrl_w.busy;
    assign err_w    = ctrl_w.err;
    assign reload_w = ctrl_w.reload;

    fuse_shadow_bank #(.WORDS(WORDS)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_hit     (wr_stb && dec.sel == SEL_SHADOW),
        .rd_hit     (rd_stb && dec.sel == SEL_SHADOW),
        .idx        (dec.idx),
        .wdata      (bus_wdata),
        .wr_lock    (wr_lock),
        .rd_lock    (rd_lock),
        .reloading  (reload_w),
        .err_q      (err_w),
        .fill_valid (fill_valid),
        .fill_idx   (fill_idx),
        .fill_data  (fill_data),
        .rd_word    (shadow_word),
        .err_evt    (shadow_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_stb) begin
            case (dec.sel)
                SEL_CTRL, SEL_CSET, SEL_CCLR: rdata_q <= ctrl_w;
                SEL_TIMING:                   rdata_q <= timing_w;
                SEL_DATA:                     rdata_q <= data_w;
                SEL_SHADOW:                   rdata_q <= shadow_word;
                default:                      rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata  = rdata_q;
    assign timing_cfg = timing_w;
    assign prog_data  = data_w;
endmodule

// File: rtl/fuse_regif_chk.sv
module fuse_regif_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_req,
    input logic        bus_we,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        prog_req,
    input logic [6:0]  prog_addr,
    input logic [31:0] prog_data,
    input logic        reload_req,
    input logic        busy,
    input logic        err,
    input logic        reloading
);
    a_r3_prog_busy: assert property (@(posedge clk) disable iff (rst)
        prog_req |-> busy);

    a_r3_prog_single: assert property (@(posedge clk) disable iff (rst)
        prog_req |=> !prog_req);

    a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(prog_addr));

    a_r4_data_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(prog_data));

    a_r9_prog_no_err: assert property (@(posedge clk) disable iff (rst)
        prog_req |-> !err);

    a_r9_err_clear_only: assert property (@(posedge clk) disable iff (rst)
        $fell(err) |-> $past(bus_req && bus_we && bus_addr == 12'h008 && bus_wdata[9]));

    a_r10_reload_busy: assert property (@(posedge clk) disable iff (rst)
        reloading |-> busy);

    a_r10_reload_pulse: assert property (@(posedge clk) disable iff (rst)
        reload_req |-> (reloading && !err && !prog_req));
endmodule

bind fuse_regif fuse_regif_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .prog_req   (prog_req),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .reload_req (reload_req),
    .busy       (busy_w),
    .err        (err_w),
    .reloading  (reload_w)
);

// File: tb/sim_fuse_regif.sv
module sim_fuse_regif;
    localparam int WORDS = 16;
    localparam logic [31:0] POISON = 32'hBADA_BADA;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [WORDS-1:0]  wr_lock = 16'h0008;
    logic [WORDS-1:0]  rd_lock = 16'h0020;
    logic [31:0]       timing_cfg;
    logic              prog_req, reload_req;
    logic [6:0]        prog_addr;
    logic [31:0]       prog_data;
    logic              seq_done = 1'b0, fill_valid = 1'b0;
    logic [6:0]        fill_idx = '0;
    logic [31:0]       fill_data = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fuse_regif #(.WORDS(WORDS)) u0 (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wr_lock(wr_lock), .rd_lock(rd_lock), .timing_cfg(timing_cfg),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .reload_req(reload_req), .seq_done(seq_done), .fill_valid(fill_valid),
        .fill_idx(fill_idx), .fill_data(fill_data)
    );

    function automatic logic [11:0] sh(input int n);
        return 12'(12'h400 + 16 * n);
    endfunction

    function automatic logic [31:0] pat(input int n);
        return 32'h0F00_0000 | 32'(n << 8) | 32'(n * 3);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic done_pulse();
        @(negedge clk); seq_done = 1'b1;
        @(negedge clk); seq_done = 1'b0;
    endtask

    task automatic fill(input logic [6:0] i, input logic [31:0] d);
        @(negedge clk); fill_valid = 1'b1; fill_idx = i; fill_data = d;
        @(negedge clk); fill_valid = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 prog_req", 32'(prog_req), 0);
        chk("R1 reload_req", 32'(reload_req), 0);
        bus_read(12'h000, rd); chk("R1 ctrl", rd, 0);
        bus_read(12'h010, rd); chk("R1 timing", rd, 0);
        bus_read(12'h020, rd); chk("R1 data", rd, 0);
        bus_read(sh(0), rd);   chk("R1 shadow", rd, 0);

        // R2 address field sweep and alias behaviour
        for (int a = 0; a < 128; a++) begin
            logic [15:0] hi;
            hi = 16'(a * 517);
            bus_write(12'h000, {hi, 16'(a)});
            bus_read(12'h000, rd);
            chk("R2 ctrl sweep", rd, {hi, 9'b0, 7'(a)});
        end
        bus_write(12'h000, 32'h0001_0005);
        bus_write(12'h004, 32'h0010_0012);
        bus_read(12'h000, rd); chk("R2 set alias", rd, 32'h0011_0017);
        bus_write(12'h008, 32'h0001_0003);
        bus_read(12'h008, rd); chk("R2 clear alias", rd, 32'h0010_0014);
        bus_write(12'h000, 32'h0);

        // R11 timing and undecoded offsets
        bus_write(12'h010, 32'h003F_FABC);
        bus_read(12'h010, rd); chk("R11 timing read", rd, 32'h003F_FABC);
        chk("R11 timing port", timing_cfg, 32'h003F_FABC);
        bus_read(12'h030, rd); chk("R11 undecoded 030", rd, 0);
        bus_read(12'h00C, rd); chk("R11 undecoded 00C", rd, 0);
        bus_read(12'h404, rd); chk("R11 unaligned shadow", rd, 0);
        bus_read(sh(WORDS), rd); chk("R11 shadow beyond words", rd, 0);

        // R7 R8 shadow sweep
        for (int n = 0; n < WORDS; n++) begin
            bus_write(sh(n), pat(n));
            if (n == 3) begin
                bus_read(12'h000, rd); chk("R8 locked shadow write error", rd, 32'h0000_0200);
                bus_write(12'h008, 32'h200);
            end
            bus_read(sh(n), rd);
            if (n == 3)      chk("R8 locked shadow unchanged", rd, 0);
            else if (n == 5) chk("R7 read-locked poison", rd, POISON);
            else             chk("R7 shadow readback", rd, pat(n));
            if (n == 5) begin
                bus_read(12'h000, rd); chk("R7 read-lock error", rd, 32'h0000_0200);
                bus_write(12'h008, 32'h200);
            end
        end

        // R3 program
        bus_write(12'h000, 32'h3E77_0002);
        bus_write(12'h020, 32'hA5A5_0F0F);
        chk("R3 prog_req", 32'(prog_req), 1);
        chk("R3 prog_addr", 32'(prog_addr), 2);
        chk("R3 prog_data", prog_data, 32'hA5A5_0F0F);
        bus_read(12'h000, rd); chk("R3 busy set, key cleared", rd, 32'h0000_0102);
        chk("R3 single pulse", 32'(prog_req), 0);

        // R4 busy protection
        bus_write(12'h000, 32'h0000_0009);
        bus_write(12'h020, 32'h0000_1234);
        bus_read(12'h020, rd); chk("R4 data held", rd, 32'hA5A5_0F0F);
        chk("R4 prog_addr held", 32'(prog_addr), 2);
        bus_write(12'h004, 32'h0000_0400);
        chk("R10 reload rejected while busy", 32'(reload_req), 0);
        bus_read(12'h000, rd); chk("R10 busy unchanged by reload", rd, 32'h0000_0109);
        done_pulse();
        bus_read(12'h000, rd); chk("R10 done clears busy", rd, 32'h0000_0009);

        // R3 key self-clears, R6 plain data write
        bus_write(12'h020, 32'h0000_0077);
        chk("R3 no prog without re-arm", 32'(prog_req), 0);
        bus_read(12'h020, rd); chk("R6 data stored", rd, 32'h0000_0077);
        bus_read(12'h000, rd); chk("R6 not busy", rd, 32'h0000_0009);

        // R5 locked word
        bus_write(12'h000, 32'h3E77_0003);
        bus_write(12'h020, 32'h0000_FFFF);
        chk("R5 no prog to locked word", 32'(prog_req), 0);
        bus_read(12'h000, rd); chk("R5 error set, key cleared", rd, 32'h0000_0203);

        // R9 error blocking
        bus_write(12'h000, 32'h3E77_0004);
        bus_write(12'h020, 32'h0000_0011);
        chk("R9 prog blocked", 32'(prog_req), 0);
        bus_read(12'h000, rd); chk("R9 still armed, not busy", rd, 32'h3E77_0204);
        bus_write(12'h004, 32'h0000_0400);
        chk("R9 reload blocked", 32'(reload_req), 0);
        bus_write(sh(0), 32'h0000_DEAD);
        bus_read(sh(0), rd); chk("R9 shadow read poisoned", rd, POISON);
        bus_write(12'h000, 32'h3E77_0004);
        bus_read(12'h000, rd); chk("R9 direct write keeps error", rd, 32'h3E77_0204);
        bus_write(12'h008, 32'h0000_0200);
        bus_read(12'h000, rd); chk("R9 clear alias clears error", rd, 32'h3E77_0004);
        bus_read(sh(0), rd); chk("R9 blocked shadow write ignored", rd, pat(0));
        bus_write(12'h020, 32'h0000_0011);
        chk("R3 prog after clear", 32'(prog_req), 1);
        chk("R3 prog_addr 4", 32'(prog_addr), 4);
        done_pulse();

        // R10 reload
        bus_write(12'h004, 32'h0000_0400);
        chk("R10 reload_req", 32'(reload_req), 1);
        bus_read(12'h000, rd); chk("R10 reload busy", rd, 32'h0000_0504);
        bus_write(sh(2), 32'h0000_BEEF);
        bus_read(12'h000, rd); chk("R8 write during reload errors", rd, 32'h0000_0704);
        fill(7'd1, 32'hCAFE_0001);
        fill(7'd7, 32'hCAFE_0007);
        done_pulse();
        bus_read(12'h000, rd); chk("R10 reload done", rd, 32'h0000_0204);
        bus_write(12'h008, 32'h0000_0200);
        fill(7'd2, 32'h0);
        bus_read(sh(1), rd); chk("R10 fill word 1", rd, 32'hCAFE_0001);
        bus_read(sh(7), rd); chk("R10 fill word 7", rd, 32'hCAFE_0007);
        bus_read(sh(2), rd); chk("R10 fill ignored when idle", rd, pat(2));

        summary();
        $finish;
    end
endmodule